// File: doc/BRIEF.md
# Prioritised Exception Entry Controller

This block decides, at every instruction boundary of a processor core, whether the core has to leave its normal flow for an exception handler, and which handler to enter. Two asynchronous active-low interrupt request lines are each brought into the clock domain through a two-flop synchroniser. A data-abort event is held pending until the next boundary. A prefetch-abort mark is carried with the fetched instruction until that instruction reaches execution. Undefined-instruction and software-interrupt events arrive with the boundary strobe.

When at least one request is eligible at a boundary, the block picks the highest-priority one under a fixed order. One clock later it issues a single-cycle entry command that holds the target mode, the vector address, the link value to save, the offset the handler must subtract on return, the status word to load and the old status word to bank. The pipeline and the register file that act on this command sit outside the block.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with no request, `entry_valid` is 0.
- R2: An entry command is issued only one clock after a cycle with `boundary` high, and `entry_valid` stays high for that single cycle.
- R3: Fast interrupt entry gives mode 5'b10001, vector VEC_BASE+0x1C, link `next_addr`+4, return offset 4, and sets status bits 7 and 6.
- R4: Normal interrupt entry gives mode 5'b10010, vector VEC_BASE+0x18, link `next_addr`+4, return offset 4, sets status bit 7 and leaves bit 6 unchanged.
- R5: A fast request is not taken while status bit 6 is 1, and a normal request is not taken while status bit 7 is 1.
- R6: A request line driven low is not seen at a boundary whose clock edge is one of the first two edges after the drop; it is seen from the third edge on.
- R7: A one-cycle `dabt_evt` pulse is held until the next boundary, where it gives mode 5'b10111, vector VEC_BASE+0x10, link `cur_addr`+8 and return offset 8; it is then cleared.
- R8: A `pf_mark` given with a boundary raises a prefetch abort at the PF_DEPTH-th later boundary (default 2), with mode 5'b10111, vector VEC_BASE+0x0C, link `next_addr`+4 and return offset 4.
- R9: A `flush` pulse discards every pending prefetch-abort mark, so no prefetch abort follows.
- R10: Undefined-instruction entry gives mode 5'b11011, vector VEC_BASE+0x04, link `cur_addr`+4 and return offset 0.
- R11: Software-interrupt entry gives mode 5'b10011, vector VEC_BASE+0x08, link `cur_addr`+4 and return offset 0.
- R12: Among eligible requests the order, highest first, is data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction, software interrupt.
- R13: `entry_spsr` equals the status word seen at the boundary. `entry_cpsr` equals that word with bits 4:0 replaced by the new mode, bit 7 set, bit 6 set for a fast interrupt, and all other bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fiq_n | input | 1 | Asynchronous fast interrupt request, active low |
| irq_n | input | 1 | Asynchronous normal interrupt request, active low |
| dabt_evt | input | 1 | Data-abort event pulse from a memory access |
| boundary | input | 1 | End of the current instruction |
| pf_mark | input | 1 | With `boundary`: the newly fetched instruction is abort-marked |
| flush | input | 1 | Pipeline refill, discards prefetch-abort marks |
| und_instr | input | 1 | With `boundary`: executing instruction is undefined |
| swi_instr | input | 1 | With `boundary`: executing instruction is a software interrupt |
| cpsr | input | 32 | Current status word |
| cur_addr | input | AW | Address of the instruction that is ending |
| next_addr | input | AW | Address of the instruction that would execute next |
| entry_valid | output | 1 | Entry command strobe |
| entry_mode | output | 5 | Target mode |
| entry_vector | output | AW | Handler address |
| entry_link | output | AW | Link value to save |
| entry_ret_off | output | 4 | Amount the handler subtracts from the link on return |
| entry_cpsr | output | 32 | New status word |
| entry_spsr | output | 32 | Old status word to bank |

## Verification
The hardest case to reach is a prefetch abort that actually fires. The mark must be given at one boundary and must survive exactly PF_DEPTH further boundaries with no flush and no other exception clearing it in between. The bench walks a mark through two empty boundaries, checks that nothing fires early, and then checks the entry at the third boundary. It repeats the walk with a flush inserted to show that the mark is discarded. The synchroniser latency is reached in a similar way: a request line is dropped and a boundary is placed on each of the next three clock edges.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic [2:0] {
    EXC_NONE, EXC_DABT, EXC_FIQ, EXC_IRQ, EXC_PABT, EXC_UND, EXC_SWI
  } exc_kind_e;

  localparam logic [4:0] MODE_FIQ = 5'b10001;
  localparam logic [4:0] MODE_IRQ = 5'b10010;
  localparam logic [4:0] MODE_SVC = 5'b10011;
  localparam logic [4:0] MODE_ABT = 5'b10111;
  localparam logic [4:0] MODE_UND = 5'b11011;

  localparam int STAT_I_BIT = 7;
  localparam int STAT_F_BIT = 6;

  typedef struct packed {
    logic [4:0] mode;
    logic [7:0] vec_off;
    logic [3:0] link_off;
    logic [3:0] ret_off;
    logic       set_f;
    logic       use_next;
  } exc_attr_t;

  function automatic exc_attr_t exc_attr(exc_kind_e k);
    exc_attr_t a;
    case (k)
      EXC_DABT: a = '{MODE_ABT, 8'h10, 4'd8, 4'd8, 1'b0, 1'b0};
      EXC_FIQ:  a = '{MODE_FIQ, 8'h1C, 4'd4, 4'd4, 1'b1, 1'b1};
      EXC_IRQ:  a = '{MODE_IRQ, 8'h18, 4'd4, 4'd4, 1'b0, 1'b1};
      EXC_PABT: a = '{MODE_ABT, 8'h0C, 4'd4, 4'd4, 1'b0, 1'b1};
      EXC_UND:  a = '{MODE_UND, 8'h04, 4'd4, 4'd0, 1'b0, 1'b0};
      EXC_SWI:  a = '{MODE_SVC, 8'h08, 4'd4, 4'd0, 1'b0, 1'b0};
      default:  a = '0;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/exc_req_sync.sv
module exc_req_sync #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_n,
  output logic [N-1:0] req
);
  for (genvar g = 0; g < N; g++) begin : g_sync
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b1;
        s2_q <= 1'b1;
      end else begin
        s1_q <= req_n[g];
        s2_q <= s1_q;
      end
    end
    assign req[g] = ~s2_q;
  end
endmodule

// File: rtl/exc_pabt_track.sv
module exc_pabt_track #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic boundary,
  input  logic mark,
  input  logic flush,
  input  logic taken,
  output logic head
);
  logic [DEPTH-1:0] chain_q, chain_nx, shifted;

  if (DEPTH == 1) begin : g_single
    assign shifted = mark;
  end else begin : g_multi
    assign shifted = {chain_q[DEPTH-2:0], mark};
  end

  always_comb begin
    chain_nx = chain_q;
    if (flush || (boundary && taken)) chain_nx = '0;
    else if (boundary)                chain_nx = shifted;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_nx;
  end

  assign head = chain_q[DEPTH-1] & ~flush;
endmodule

// File: rtl/exc_prio.sv
module exc_prio
  import exc_pkg::*;
(
  input  logic      dabt,
  input  logic      fiq,
  input  logic      irq,
  input  logic      pabt,
  input  logic      und,
  input  logic      swi,
  output exc_kind_e kind
);
  always_comb begin
    if      (dabt) kind = EXC_DABT;
    else if (fiq)  kind = EXC_FIQ;
    else if (irq)  kind = EXC_IRQ;
    else if (pabt) kind = EXC_PABT;
    else if (und)  kind = EXC_UND;
    else if (swi)  kind = EXC_SWI;
    else           kind = EXC_NONE;
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int            AW       = 32,
  parameter int            PF_DEPTH = 2,
  parameter logic [AW-1:0] VEC_BASE = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fiq_n,
  input  logic          irq_n,
  input  logic          dabt_evt,
  input  logic          boundary,
  input  logic          pf_mark,
  input  logic          flush,
  input  logic          und_instr,
  input  logic          swi_instr,
  input  logic [31:0]   cpsr,
  input  logic [AW-1:0] cur_addr,
  input  logic [AW-1:0] next_addr,
  output logic          entry_valid,
  output logic [4:0]    entry_mode,
  output logic [AW-1:0] entry_vector,
  output logic [AW-1:0] entry_link,
  output logic [3:0]    entry_ret_off,
  output logic [31:0]   entry_cpsr,
  output logic [31:0]   entry_spsr
);
  localparam int PAD_V = AW - 8;
  localparam int PAD_L = AW - 4;

  logic [1:0] irq_lines;
  logic       fiq_req, irq_req, pabt_head;
  logic       dabt_q, dabt_nx, dabt_any;
  logic       take;
  exc_kind_e  kind;
  exc_attr_t  attr;
  logic [AW-1:0] link_nx, vec_nx;
  logic [31:0]   cpsr_nx;

  exc_req_sync #(.N(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .req_n({fiq_n, irq_n}), .req(irq_lines)
  );
  assign fiq_req = irq_lines[1];
  assign irq_req = irq_lines[0];

  exc_pabt_track #(.DEPTH(PF_DEPTH)) u_pabt (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .mark(pf_mark),
    .flush(flush), .taken(take), .head(pabt_head)
  );

  assign dabt_any = dabt_q | dabt_evt;

  exc_prio u_prio (
    .dabt(dabt_any),
    .fiq (fiq_req & ~cpsr[STAT_F_BIT]),
    .irq (irq_req & ~cpsr[STAT_I_BIT]),
    .pabt(pabt_head),
    .und (und_instr),
    .swi (swi_instr),
    .kind(kind)
  );

  assign take = boundary && (kind != EXC_NONE);

  always_comb begin
    attr    = exc_attr(kind);
    dabt_nx = (take && kind == EXC_DABT) ? 1'b0 : dabt_any;
    link_nx = (attr.use_next ? next_addr : cur_addr) + {{PAD_L{1'b0}}, attr.link_off};
    vec_nx  = VEC_BASE + {{PAD_V{1'b0}}, attr.vec_off};
    cpsr_nx = cpsr;
    cpsr_nx[4:0]        = attr.mode;
    cpsr_nx[STAT_I_BIT] = 1'b1;
    cpsr_nx[STAT_F_BIT] = cpsr[STAT_F_BIT] | attr.set_f;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dabt_q      <= 1'b0;
      entry_valid <= 1'b0;
    end else begin
      dabt_q      <= dabt_nx;
      entry_valid <= take;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry_mode    <= '0;
      entry_vector  <= '0;
      entry_link    <= '0;
      entry_ret_off <= '0;
      entry_cpsr    <= '0;
      entry_spsr    <= '0;
    end else if (take) begin
      entry_mode    <= attr.mode;
      entry_vector  <= vec_nx;
      entry_link    <= link_nx;
      entry_ret_off <= attr.ret_off;
      entry_cpsr    <= cpsr_nx;
      entry_spsr    <= cpsr;
    end
  end

  AST_ENTRY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    entry_valid |-> $past(boundary)); // R2
  AST_FIQ_BOTH_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_valid && entry_mode == MODE_FIQ) |-> (entry_cpsr[7] && entry_cpsr[6])); // R3
  AST_IRQ_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_valid && entry_mode == MODE_IRQ) |-> !$past(cpsr[STAT_I_BIT])); // R5
  AST_DABT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && dabt_any) |=> (entry_valid && entry_mode == MODE_ABT && entry_ret_off == 4'd8)); // R12
  AST_FIQ_OVER_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !dabt_any && fiq_req && !cpsr[STAT_F_BIT]) |=> (entry_mode == MODE_FIQ)); // R12
  AST_SPSR_BANKED: assert property (@(posedge clk) disable iff (!rst_n)
    entry_valid |-> (entry_spsr == $past(cpsr))); // R13
endmodule

// File: tb/exc_entry_ctrl_bench.sv
module exc_entry_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        fiq_n, irq_n, dabt_evt, boundary, pf_mark, flush, und_instr, swi_instr;
  logic [31:0] cpsr, cur_addr, next_addr;
  logic        entry_valid;
  logic [4:0]  entry_mode;
  logic [31:0] entry_vector, entry_link, entry_cpsr, entry_spsr;
  logic [3:0]  entry_ret_off;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  exc_entry_ctrl u_exc_entry_ctrl (
    .clk(clk), .rst_n(rst_n), .fiq_n(fiq_n), .irq_n(irq_n), .dabt_evt(dabt_evt),
    .boundary(boundary), .pf_mark(pf_mark), .flush(flush), .und_instr(und_instr),
    .swi_instr(swi_instr), .cpsr(cpsr), .cur_addr(cur_addr), .next_addr(next_addr),
    .entry_valid(entry_valid), .entry_mode(entry_mode), .entry_vector(entry_vector),
    .entry_link(entry_link), .entry_ret_off(entry_ret_off), .entry_cpsr(entry_cpsr),
    .entry_spsr(entry_spsr)
  );

  // kind codes: 0 none, 1 data abort, 2 fast, 3 normal, 4 prefetch abort, 5 undefined, 6 software
  typedef struct packed {
    logic [31:0] st;
    logic [31:0] cur;
    logic [31:0] nxt;
    logic        f_n, i_n, dab, und, swi;
    logic [2:0]  kind;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{32'h0000_0010, 32'h1000, 32'h1004, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd2},
    '{32'h2000_0010, 32'h1100, 32'h1104, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd3},
    '{32'h0000_0030, 32'h1200, 32'h1204, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd2},
    '{32'h0000_0050, 32'h1300, 32'h1304, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd3},
    '{32'h0000_0090, 32'h1400, 32'h1404, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0},
    '{32'h0000_00D0, 32'h1500, 32'h1504, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0},
    '{32'hF000_0010, 32'h2000, 32'h2004, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd1},
    '{32'h8000_0013, 32'h3000, 32'h3004, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 3'd5},
    '{32'h4000_0010, 32'h3100, 32'h3104, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 3'd6},
    '{32'h0000_0010, 32'h3200, 32'h3204, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 3'd3},
    '{32'h0000_0010, 32'h3300, 32'h3304, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 3'd5},
    '{32'h0000_0010, 32'h3400, 32'h3404, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // boundary strobe for one clock; results are visible on return
  task automatic bound(input logic m, input logic u, input logic s);
    boundary = 1'b1; pf_mark = m; und_instr = u; swi_instr = s;
    @(negedge clk);
    boundary = 1'b0; pf_mark = 1'b0; und_instr = 1'b0; swi_instr = 1'b0;
  endtask

  task automatic expect_entry(input int kind, input string req);
    logic [4:0]  m;
    logic [31:0] v, l, c;
    logic [3:0]  r;
    check({req, " valid"}, {31'd0, entry_valid}, {31'd0, kind != 0});
    if (kind == 0) return;
    case (kind)
      1: begin m = 5'b10111; v = 32'h10; l = cur_addr + 8;  r = 4'd8; end
      2: begin m = 5'b10001; v = 32'h1C; l = next_addr + 4; r = 4'd4; end
      3: begin m = 5'b10010; v = 32'h18; l = next_addr + 4; r = 4'd4; end
      4: begin m = 5'b10111; v = 32'h0C; l = next_addr + 4; r = 4'd4; end
      5: begin m = 5'b11011; v = 32'h04; l = cur_addr + 4;  r = 4'd0; end
      default: begin m = 5'b10011; v = 32'h08; l = cur_addr + 4; r = 4'd0; end
    endcase
    c = {cpsr[31:8], 1'b1, cpsr[6] | (kind == 2), cpsr[5], m};
    check({req, " mode"},   {27'd0, entry_mode}, {27'd0, m});
    check({req, " vector"}, entry_vector, v);
    check({req, " link"},   entry_link, l);
    check({req, " retoff"}, {28'd0, entry_ret_off}, {28'd0, r});
    check("R13 cpsr",       entry_cpsr, c);
    check("R13 spsr",       entry_spsr, cpsr);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fiq_n = 1'b1; irq_n = 1'b1; dabt_evt = 1'b0; boundary = 1'b0;
    pf_mark = 1'b0; flush = 1'b0; und_instr = 1'b0; swi_instr = 1'b0;
    cpsr = 32'h10; cur_addr = 32'h100; next_addr = 32'h104;
    repeat (3) @(negedge clk);
    check("R1 in reset", {31'd0, entry_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after reset", {31'd0, entry_valid}, 32'd0);

    // table walk: R3 R4 R5 R7 R10 R11 R12 R13
    for (int k = 0; k < NV; k++) begin
      cpsr = TBL[k].st; cur_addr = TBL[k].cur; next_addr = TBL[k].nxt;
      fiq_n = TBL[k].f_n; irq_n = TBL[k].i_n;
      repeat (3) @(negedge clk);
      if (TBL[k].dab) begin
        dabt_evt = 1'b1; @(negedge clk); dabt_evt = 1'b0;
      end
      bound(1'b0, TBL[k].und, TBL[k].swi);
      expect_entry(int'(TBL[k].kind), "R12 table");
      @(negedge clk);
      check("R2 single pulse", {31'd0, entry_valid}, 32'd0);
      fiq_n = 1'b1; irq_n = 1'b1;
      repeat (3) @(negedge clk);
    end

    // R6: request seen only from the third edge after the drop
    cpsr = 32'h10; cur_addr = 32'h5000; next_addr = 32'h5004;
    fiq_n = 1'b0;
    bound(1'b0, 1'b0, 1'b0);
    expect_entry(0, "R6 edge1");
    bound(1'b0, 1'b0, 1'b0);
    expect_entry(0, "R6 edge2");
    bound(1'b0, 1'b0, 1'b0);
    expect_entry(2, "R6 edge3");
    fiq_n = 1'b1;
    repeat (3) @(negedge clk);

    // R7: data abort held across idle cycles, then cleared
    cur_addr = 32'h6000; next_addr = 32'h6004;
    dabt_evt = 1'b1; @(negedge clk); dabt_evt = 1'b0;
    repeat (4) @(negedge clk);
    bound(1'b0, 1'b0, 1'b0);
    expect_entry(1, "R7 held");
    bound(1'b0, 1'b0, 1'b0);
    expect_entry(0, "R7 cleared");

    // R8: mark reaches execution at the second later boundary
    cur_addr = 32'h7000; next_addr = 32'h7004;
    bound(1'b1, 1'b0, 1'b0);
    expect_entry(0, "R8 marked");
    bound(1'b0, 1'b0, 1'b0);
    expect_entry(0, "R8 in flight");
    bound(1'b0, 1'b0, 1'b0);
    expect_entry(4, "R8 raised");
    bound(1'b0, 1'b0, 1'b0);
    expect_entry(0, "R8 once");

    // R9: flush discards the mark
    bound(1'b1, 1'b0, 1'b0);
    flush = 1'b1; @(negedge clk); flush = 1'b0;
    bound(1'b0, 1'b0, 1'b0);
    expect_entry(0, "R9 flushed a");
    bound(1'b0, 1'b0, 1'b0);
    expect_entry(0, "R9 flushed b");

    // R12: prefetch abort loses to normal interrupt, mark consumed
    bound(1'b1, 1'b0, 1'b0);
    bound(1'b0, 1'b0, 1'b0);
    irq_n = 1'b0;
    repeat (3) @(negedge clk);
    bound(1'b0, 1'b0, 1'b0);
    expect_entry(3, "R12 irq over pabt");
    irq_n = 1'b1;
    repeat (3) @(negedge clk);
    bound(1'b0, 1'b0, 1'b0);
    expect_entry(0, "R12 pabt dropped");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule